// File: doc/BRIEF.md
# Fine-Lock Timing Controller

This block sequences the locking of a mirror-delay clock deskew loop. When `en` is raised, it first lets a fixed coarse-lock window of two reference cycles pass, then raises `coarse_done`. It then enters a fine search that moves a 3-bit fine-tune code, which drives a trim delay line. The search is steered by an early/late decision from a phase detector.

The fine search has four update slots, spaced two reference cycles apart. The cycle between slots lets the trimmed delay line and the phase detector settle before the next decision is taken. The code starts at mid-scale (3'b100). The first slot moves it by two steps and the remaining three slots move it by one step each, giving a successive-approximation style search that stays inside the range 0 to 7. After the fourth slot the controller raises `locked` and freezes the code. Lock is therefore reached exactly ten reference edges after enable. Dropping `en` at any time returns the controller to idle.

Top module: `fine_lock_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active-low), the controller goes idle: `ftc` = 3'b100 (4), and `coarse_done` and `locked` are 0.
- R2: Counting the rising edges at which `en` is sampled high from idle as 1, 2, 3 and so on, `coarse_done` is 0 after edge 1 and becomes 1 after edge 2. It stays 1 while `en` stays high.
- R3: `ftc` can change only at edges 4, 6, 8 and 10. At every other edge it holds, whatever `up` and `dn` are.
- R4: At a slot edge, `up`=1 with `dn`=0 raises `ftc`, and `dn`=1 with `up`=0 lowers it. The step is 2 at edge 4 and 1 at edges 6, 8 and 10.
- R5: At a slot edge where `up` and `dn` are equal (both 0 or both 1), `ftc` keeps its value.
- R6: `ftc` saturates at 7 on an upward step and at 0 on a downward step. It never wraps.
- R7: `locked` is 0 before edge 10 and becomes 1 after edge 10. While `en` stays high it then stays 1 and `ftc` stays frozen.
- R8: An edge with `en` sampled low returns the controller to idle (`ftc` = 4, both flags 0) from any phase. The next enable starts a fresh count at edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Loop enable; low forces idle |
| up | input | 1 | Phase detector: request more delay |
| dn | input | 1 | Phase detector: request less delay |
| ftc | output | 3 | Fine-tune control code |
| coarse_done | output | 1 | Coarse window has elapsed |
| locked | output | 1 | Fine search complete |

## Verification
The search is driven with six four-slot decision patterns:
- all up and all down, which reach the saturation corners;
- alternating up/down in both phases, which separates the two-step first slot from the one-step later slots;
- a pattern with a tie and an idle decision, which must hold the code;
- a pattern with a descending tail.

On every non-slot edge the bench drives a live up or down request, so an update that lands in the wrong cycle shows up as a moved code. Directed runs cover reset in the middle of a search, enable dropped during the fine phase, and restart after a completed lock.

// File: rtl/fine_lock_pkg.sv
// Shared types for the fine-lock timing controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package fine_lock_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2,
        ST_LOCK   = 2'd3
    } fl_state_e;

endpackage

// File: rtl/fl_phase_seq.sv
// Phase sequencer: counts the coarse window, then paces the fine-search
// slots one every SLOT_CYC cycles, and declares lock after the last slot.
// Assumes: COARSE_CYC >= 2, SLOT_CYC >= 2, NUM_SLOTS >= 2; en is synchronous.
module fl_phase_seq
    import fine_lock_pkg::*;
#(
    parameter int COARSE_CYC = 2,
    parameter int SLOT_CYC   = 2,
    parameter int NUM_SLOTS  = 4,
    localparam int CNT_MAX   = (COARSE_CYC > SLOT_CYC) ? COARSE_CYC : SLOT_CYC,
    localparam int CNT_W     = $clog2(CNT_MAX + 1),
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic              slot_fire,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              coarse_done,
    output logic              locked
);

    fl_state_e         state;
    logic [CNT_W-1:0]  cnt;

    // Purpose: flag the cycle whose closing edge applies a fine update.
    always_comb begin
        slot_fire = en && (state == ST_FINE) && (cnt == CNT_W'(SLOT_CYC - 1));
    end

    // Purpose: advance through idle, coarse, fine and lock phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            slot_idx    <= '0;
            coarse_done <= 1'b0;
            locked      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state <= ST_COARSE;
                    cnt   <= CNT_W'(1);
                end
                ST_COARSE: begin
                    if (cnt == CNT_W'(COARSE_CYC - 1)) begin
                        state       <= ST_FINE;
                        cnt         <= '0;
                        coarse_done <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_FINE: begin
                    if (slot_fire) begin
                        cnt <= '0;
                        if (slot_idx == SLOT_W'(NUM_SLOTS - 1)) begin
                            state  <= ST_LOCK;
                            locked <= 1'b1;
                        end else begin
                            slot_idx <= slot_idx + SLOT_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: lock implies the coarse window was passed
    a_r7_lock_after_coarse: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> coarse_done);

    // R7: lock persists while enabled
    a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && en) |=> locked);

    // R3: slots are never back-to-back
    a_r3_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        slot_fire |=> !slot_fire);

    // R2: coarse completion only follows an enabled cycle
    a_r2_coarse_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coarse_done) |-> $past(en));

endmodule

// File: rtl/fl_pd_decode.sv
// Decision decoder: turns the phase detector's up/down pair into a single
// increase or decrease request; equal inputs give no request.
// Assumes: up and dn are synchronous to the reference clock.
module fl_pd_decode (
    input  logic up,
    input  logic dn,
    output logic inc,
    output logic dec
);

    // Purpose: reject ties and idle decisions.
    always_comb begin
        inc = up & ~dn;
        dec = dn & ~up;
    end

endmodule

// File: rtl/fl_code_step.sv
// Code stepper: holds the fine-tune code, steps it at each slot by a
// slot-dependent size and clamps it to the code range.
// Assumes: slot_fire comes from the phase sequencer; en low means idle.
module fl_code_step #(
    parameter int CODE_W    = 3,
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int WIDE_W   = CODE_W + 2,
    localparam int CODE_MID = 1 << (CODE_W - 1),
    localparam int CODE_MAX = (1 << CODE_W) - 1,
    localparam int BIG_STEP = (CODE_MID / 2 > 0) ? CODE_MID / 2 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              slot_fire,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              inc,
    input  logic              dec,
    output logic [CODE_W-1:0] code
);

    logic [WIDE_W-1:0] wide_code;
    logic [WIDE_W-1:0] step;
    logic [WIDE_W-1:0] raised;
    logic [WIDE_W-1:0] lowered;

    // Purpose: choose the step size of the current slot and clamp both moves.
    always_comb begin
        wide_code = WIDE_W'(code);
        step      = (slot_idx == '0) ? WIDE_W'(BIG_STEP) : WIDE_W'(1);
        raised    = wide_code + step;
        if (raised > WIDE_W'(CODE_MAX)) begin
            raised = WIDE_W'(CODE_MAX);
        end
        lowered   = (step > wide_code) ? '0 : (wide_code - step);
    end

    // Purpose: hold or update the code register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            code <= CODE_W'(CODE_MID);
        end else if (slot_fire && inc) begin
            code <= raised[CODE_W-1:0];
        end else if (slot_fire && dec) begin
            code <= lowered[CODE_W-1:0];
        end
    end

    // R3: no change outside a slot
    a_r3_hold_off_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !slot_fire) |=> $stable(code));

    // R4: an increase request never lowers the code
    a_r4_inc_direction: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fire && inc) |=> (code >= $past(code)));

    // R4: a decrease request never raises the code
    a_r4_dec_direction: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fire && dec) |=> (code <= $past(code)));

    // R8: disabling restores mid-scale
    a_r8_idle_mid: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (code == CODE_W'(CODE_MID)));

endmodule

// File: rtl/fine_lock_ctrl.sv
// Fine-lock timing controller top: a coarse window followed by a paced
// successive-approximation search of the fine-tune code.
// Assumes: up/dn are already synchronous to clk; reset is synchronous.
module fine_lock_ctrl #(
    parameter int CODE_W     = 3,
    parameter int COARSE_CYC = 2,
    parameter int SLOT_CYC   = 2,
    parameter int NUM_SLOTS  = 4,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              up,
    input  logic              dn,
    output logic [CODE_W-1:0] ftc,
    output logic              coarse_done,
    output logic              locked
);

    logic              slot_fire;
    logic [SLOT_W-1:0] slot_idx;
    logic              inc;
    logic              dec;

    fl_phase_seq #(
        .COARSE_CYC (COARSE_CYC),
        .SLOT_CYC   (SLOT_CYC),
        .NUM_SLOTS  (NUM_SLOTS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .slot_fire   (slot_fire),
        .slot_idx    (slot_idx),
        .coarse_done (coarse_done),
        .locked      (locked)
    );

    fl_pd_decode u_dec (
        .up  (up),
        .dn  (dn),
        .inc (inc),
        .dec (dec)
    );

    fl_code_step #(
        .CODE_W    (CODE_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .slot_fire (slot_fire),
        .slot_idx  (slot_idx),
        .inc       (inc),
        .dec       (dec),
        .code      (ftc)
    );

    // R5: a tied or empty decision leaves the code alone
    a_r5_tie_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fire && (up == dn)) |=> $stable(ftc));

    // R7: once locked and still enabled, the code is frozen
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && en) |=> $stable(ftc));

endmodule

// File: tb/tb_fine_lock_ctrl.sv
`timescale 1ns/1ps
module tb_fine_lock_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       up;
    logic       dn;
    logic [2:0] ftc;
    logic       coarse_done;
    logic       locked;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fine_lock_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .up          (up),
        .dn          (dn),
        .ftc         (ftc),
        .coarse_done (coarse_done),
        .locked      (locked)
    );

    // Vector: [19:8] expected code after slots 3..0 (3 bits each, slot i at 3i),
    //         [7:0] decisions {up,dn} for slots 3..0 (slot i at 2i).
    localparam logic [19:0] VEC [6] = '{
        {3'd7, 3'd7, 3'd7, 3'd6, 2'b10, 2'b10, 2'b10, 2'b10},  // all up, saturates
        {3'd0, 3'd0, 3'd1, 3'd2, 2'b01, 2'b01, 2'b01, 2'b01},  // all down, saturates
        {3'd5, 3'd6, 3'd5, 3'd6, 2'b01, 2'b10, 2'b01, 2'b10},  // up,dn,up,dn
        {3'd3, 3'd2, 3'd3, 3'd2, 2'b10, 2'b01, 2'b10, 2'b01},  // dn,up,dn,up
        {3'd4, 3'd5, 3'd5, 3'd4, 2'b01, 2'b11, 2'b10, 2'b00},  // idle,up,tie,dn
        {3'd3, 3'd4, 3'd5, 3'd6, 2'b01, 2'b01, 2'b01, 2'b10}   // up,dn,dn,dn
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic string tag_of(input int v);
        if (v <= 1) return "R6";
        if (v == 4) return "R5";
        return "R4";
    endfunction

    // Starts at a negedge with the controller idle; runs a full lock and disables.
    task automatic run_vec(input logic [19:0] vec, input string tag);
        int prev = 4;
        en = 1'b1;
        for (int e = 1; e <= 12; e++) begin
            bit is_slot = (e >= 4) && (e <= 10) && (e % 2 == 0);
            int s = (e - 4) / 2;
            if (is_slot) begin
                {up, dn} = vec[2*s +: 2];
            end else begin
                {up, dn} = (e % 2 == 1) ? 2'b10 : 2'b01;  // R3: live noise off-slot
            end
            @(negedge clk);
            chk(coarse_done == (e >= 2), "R2", int'(coarse_done), int'(e >= 2));
            chk(locked == (e >= 10), "R7", int'(locked), int'(e >= 10));
            if (is_slot) begin
                int exp_code = int'(vec[8 + 3*s +: 3]);
                chk(int'(ftc) == exp_code, tag, int'(ftc), exp_code);
                prev = exp_code;
            end else begin
                chk(int'(ftc) == prev, (e > 10) ? "R7" : "R3", int'(ftc), prev);
            end
        end
        en = 1'b0;
        @(negedge clk);
        chk(ftc == 3'd4 && !coarse_done && !locked, "R8",
            int'({ftc, coarse_done, locked}), 16);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; up = 1'b0; dn = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk(ftc == 3'd4, "R1", int'(ftc), 4);
        chk(!coarse_done && !locked, "R1", int'({coarse_done, locked}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            run_vec(VEC[v], tag_of(v));
        end

        // R1: reset in the middle of a search (enable held high)
        en = 1'b1; up = 1'b1; dn = 1'b0;
        repeat (5) @(negedge clk);
        chk(ftc == 3'd6, "R4", int'(ftc), 6);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ftc == 3'd4 && !coarse_done && !locked, "R1",
            int'({ftc, coarse_done, locked}), 16);
        rst_n = 1'b1;
        // R2: fresh count after reset release with en still high
        @(negedge clk);
        chk(!coarse_done, "R2", int'(coarse_done), 0);
        @(negedge clk);
        chk(coarse_done, "R2", int'(coarse_done), 1);

        // R8: drop enable during the fine phase
        up = 1'b0; dn = 1'b1;
        repeat (3) @(negedge clk);   // edges 3,4,5: slot at edge 4 lowers by 2
        chk(ftc == 3'd2, "R4", int'(ftc), 2);
        en = 1'b0;
        @(negedge clk);
        chk(ftc == 3'd4 && !coarse_done && !locked, "R8",
            int'({ftc, coarse_done, locked}), 16);

        // R8: restart after a drop behaves like a fresh run
        run_vec(VEC[2], "R8");

        finish_run();
    end

endmodule